// File: doc/BRIEF.md
# Card Response Manchester Frame Encoder

This block turns a card's response bytes into a sequence of half-bit-period load-modulation levels. A shared timing strobe (`halfTick`) marks the start of each half-period. The output `modOut` holds one level for each half-period: 1 means modulated and 0 means unmodulated. A `trigger` pulse arms the encoder and latches a response delay and a frame mode. The delay is counted in strobes. After it runs out, the encoder emits a fixed eight-half-period start-of-frame pattern. Then it emits the data bytes, each bit as a pair of half-periods with the least significant bit first. It closes the frame with a fixed eight-half-period end-of-frame pattern.

Bytes come in over a valid/ready interface with a last flag. `inReady` is high only in the strobe cycle that opens a byte slot, so upstream logic must present the next byte before that slot. If no byte is valid at a slot, the encoder raises a sticky `underflow` flag and goes straight to the end-of-frame pattern. A second frame mode sends the start-of-frame pattern alone. This mode serves as the short presence answer. CRC generation, subcarrier generation and command decoding belong to neighbouring blocks.

Top module: `mfe_top`

## Requirements
- R1: After reset, and in every cycle where `busy` is low, `modOut` is 0. `busy` and `underflow` are 0 after reset. A reset in the middle of a frame returns the block to idle at once.
- R2: An accepted trigger latches `delayVal` (D). `modOut` stays 0 for the first D strobes after the trigger. The first start-of-frame half-period begins on strobe D+1, or on the first strobe when D is 0.
- R3: The start-of-frame is eight half-periods, one per strobe, with levels 0,0,0,1,1,1,0,1 in time order (1 = modulated).
- R4: Each data bit takes two half-periods. A 1 is sent as 0 then 1, and a 0 is sent as 1 then 0. Bit 0 of each byte goes first, a byte takes 16 half-periods, and consecutive bytes follow with no gap.
- R5: A byte is taken in a cycle where `inValid` and `inReady` are both high. `inReady` is high only in a strobe cycle that opens a byte slot, which is either right after the start-of-frame or after the 16th half-period of a byte not flagged `inLast`. The byte taken with `inLast` high is the last of the frame. Frames of 8 and of 10 bytes are sent whole.
- R6: The last byte is followed directly by the end-of-frame: eight half-periods with levels 1,0,1,1,1,0,0,0 in time order.
- R7: If `sofOnly` is high with the accepted trigger, the frame is the start-of-frame alone. No byte is taken and no end-of-frame follows.
- R8: `busy` rises in the cycle after an accepted trigger and stays high until the strobe that ends the final half-period. In that same cycle `modOut` returns to 0.
- R9: When a byte slot opens with `inValid` low, `underflow` is set and the end-of-frame starts in that strobe. `underflow` holds until the next accepted trigger clears it.
- R10: A trigger while `busy` is high is ignored and does not change the frame in progress.
- R11: `modOut` changes only in cycles where `halfTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfTick | input | 1 | One-cycle strobe at each half-bit-period boundary |
| trigger | input | 1 | Starts a response when idle |
| sofOnly | input | 1 | Frame mode, sampled with trigger: 1 = start-of-frame only |
| delayVal | input | DLY_W | Response delay in strobes, sampled with trigger |
| inData | input | 8 | Response byte |
| inValid | input | 1 | `inData` holds a byte |
| inLast | input | 1 | The offered byte is the last of the frame |
| inReady | output | 1 | A byte slot opens in this cycle |
| modOut | output | 1 | Load-modulation enable for the current half-period |
| busy | output | 1 | A response is pending or being sent |
| underflow | output | 1 | Sticky: a byte slot found no valid byte |

## Verification
A table of frames drives the encoder with varied delays (typical 21, zero and small values), frame lengths of 8, 10, 3, 2 and 1 bytes, byte values that include 0x00 and mixed bit patterns, a start-of-frame-only frame, and starved frames that run dry after three bytes or at the very first slot. Each recorded half-period is compared with a sequence the bench builds from the pattern and bit rules. Mismatches are sorted into the delay, start-of-frame, data and end-of-frame regions, so a bit-order or polarity fault shows up apart from a pattern or delay fault. The number of bytes taken tells a correct handshake from an extra or missing transfer, and the underflow flag tells a starved frame from a normal one. Directed tests cover a repeated trigger during a frame, a reset in the middle of a frame, and the state right after reset.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  // Frame geometry
  localparam int BYTE_W        = 8;
  localparam int PAT_LEN       = 8;
  localparam int HALF_PER_BYTE = 2 * BYTE_W;
  localparam int IDX_W         = $clog2(HALF_PER_BYTE) + 1;
  localparam int PAT_IDX_W     = $clog2(PAT_LEN);

  // Fixed framing patterns, bit i is the level of half-period i (1 = modulated)
  localparam logic [PAT_LEN-1:0] SOF_PAT = 8'b1011_1000;
  localparam logic [PAT_LEN-1:0] EOF_PAT = 8'b0001_1101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SOF,
    ST_DATA,
    ST_EOF
  } phase_e;

  typedef enum logic [1:0] {
    SRC_QUIET,
    SRC_SOF,
    SRC_DATA,
    SRC_EOF
  } src_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             tick;
    logic             loadByte;
    src_e             src;
    logic [IDX_W-1:0] idx;
  } strobe_t;

endpackage

// File: rtl/mfe_ctrl.sv
module mfe_ctrl
  import mfe_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             trigger,
  input  logic             sofOnly,
  input  logic [DLY_W-1:0] delayVal,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             busy,
  output logic             underflow,
  output strobe_t          ctl
);

  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] PAT_END  = IDX_W'(PAT_LEN);
  localparam logic [IDX_W-1:0] BYTE_END = IDX_W'(HALF_PER_BYTE);

  phase_e           st, stNext;
  logic [DLY_W-1:0] delayCnt, cntNext;
  logic [IDX_W-1:0] halfIdx, idxNext;
  logic             lastSeen, lastNext;
  logic             sofOnlyReg, sofNext;
  logic             uflReg, uflNext;
  logic             needByte;

  always_comb begin
    stNext       = st;
    cntNext      = delayCnt;
    idxNext      = halfIdx;
    lastNext     = lastSeen;
    sofNext      = sofOnlyReg;
    uflNext      = uflReg;
    needByte     = 1'b0;
    ctl.tick     = halfTick;
    ctl.loadByte = 1'b0;
    ctl.src      = SRC_QUIET;
    ctl.idx      = '0;

    unique case (st)
      ST_IDLE: begin
        if (trigger) begin
          stNext  = ST_WAIT;
          cntNext = delayVal;
          sofNext = sofOnly;
          uflNext = 1'b0;
        end
      end
      ST_WAIT: begin
        if (halfTick) begin
          if (delayCnt == '0) begin
            ctl.src = SRC_SOF;
            stNext  = ST_SOF;
            idxNext = IDX_ONE;
          end else begin
            cntNext = delayCnt - 1'b1;
          end
        end
      end
      ST_SOF: begin
        if (halfTick) begin
          if (halfIdx < PAT_END) begin
            ctl.src = SRC_SOF;
            ctl.idx = halfIdx;
            idxNext = halfIdx + IDX_ONE;
          end else if (sofOnlyReg) begin
            stNext = ST_IDLE;
          end else begin
            needByte = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (halfTick) begin
          if (halfIdx < BYTE_END) begin
            ctl.src = SRC_DATA;
            ctl.idx = halfIdx;
            idxNext = halfIdx + IDX_ONE;
          end else if (lastSeen) begin
            ctl.src = SRC_EOF;
            stNext  = ST_EOF;
            idxNext = IDX_ONE;
          end else begin
            needByte = 1'b1;
          end
        end
      end
      ST_EOF: begin
        if (halfTick) begin
          if (halfIdx < PAT_END) begin
            ctl.src = SRC_EOF;
            ctl.idx = halfIdx;
            idxNext = halfIdx + IDX_ONE;
          end else begin
            stNext = ST_IDLE;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase

    // Byte slot: take the next byte or fall through to end-of-frame
    if (needByte) begin
      if (inValid) begin
        ctl.loadByte = 1'b1;
        ctl.src      = SRC_DATA;
        ctl.idx      = '0;
        stNext       = ST_DATA;
        idxNext      = IDX_ONE;
        lastNext     = inLast;
      end else begin
        uflNext = 1'b1;
        ctl.src = SRC_EOF;
        ctl.idx = '0;
        stNext  = ST_EOF;
        idxNext = IDX_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      delayCnt   <= '0;
      halfIdx    <= '0;
      lastSeen   <= 1'b0;
      sofOnlyReg <= 1'b0;
      uflReg     <= 1'b0;
    end else begin
      st         <= stNext;
      delayCnt   <= cntNext;
      halfIdx    <= idxNext;
      lastSeen   <= lastNext;
      sofOnlyReg <= sofNext;
      uflReg     <= uflNext;
    end
  end

  assign inReady   = needByte;
  assign busy      = (st != ST_IDLE);
  assign underflow = uflReg;

  // R9
  underflow_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uflReg) |-> (st == ST_EOF));

  // R10
  retrigger_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && st != ST_WAIT) |=> (st != ST_WAIT));

endmodule

// File: rtl/mfe_datapath.sv
module mfe_datapath
  import mfe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [BYTE_W-1:0] inData,
  output logic              modOut
);

  logic [BYTE_W-1:0]        byteReg;
  logic [BYTE_W-1:0]        curByte;
  logic [HALF_PER_BYTE-1:0] halves;
  logic                     modNext;

  // The first half-period of a fresh byte comes straight from the input
  assign curByte = ctl.loadByte ? inData : byteReg;

  // A 1 bit is unmodulated then modulated, a 0 bit the reverse, LSB first
  for (genvar g = 0; g < BYTE_W; g++) begin : g_halves
    assign halves[2*g]   = ~curByte[g];
    assign halves[2*g+1] =  curByte[g];
  end

  always_comb begin
    unique case (ctl.src)
      SRC_SOF:  modNext = SOF_PAT[ctl.idx[PAT_IDX_W-1:0]];
      SRC_EOF:  modNext = EOF_PAT[ctl.idx[PAT_IDX_W-1:0]];
      SRC_DATA: modNext = halves[ctl.idx[IDX_W-2:0]];
      default:  modNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modOut  <= 1'b0;
      byteReg <= '0;
    end else if (ctl.tick) begin
      modOut <= modNext;
      if (ctl.loadByte) byteReg <= inData;
    end
  end

  // R11
  mod_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.tick |=> $stable(modOut));

  // R4
  data_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tick && ctl.src == SRC_DATA) |-> (ctl.idx < IDX_W'(HALF_PER_BYTE)));

endmodule

// File: rtl/mfe_top.sv
module mfe_top
  import mfe_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             trigger,
  input  logic             sofOnly,
  input  logic [DLY_W-1:0] delayVal,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             modOut,
  output logic             busy,
  output logic             underflow
);

  strobe_t ctl;

  mfe_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .halfTick  (halfTick),
    .trigger   (trigger),
    .sofOnly   (sofOnly),
    .delayVal  (delayVal),
    .inValid   (inValid),
    .inLast    (inLast),
    .inReady   (inReady),
    .busy      (busy),
    .underflow (underflow),
    .ctl       (ctl)
  );

  mfe_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inData (inData),
    .modOut (modOut)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !modOut);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(halfTick));

  // R5
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && halfTick));

endmodule

// File: tb/test_mfe_top.sv
module test_mfe_top;

  typedef struct packed {
    logic [7:0] dly;
    logic [4:0] nBytes;
    logic       sofOnly;
    logic       starve;
    logic       retrig;
  } case_t;

  localparam int NCASE = 7;
  localparam case_t CASES [NCASE] = '{
    '{8'd21, 5'd8,  1'b0, 1'b0, 1'b0},  // typical delay, 8-byte frame
    '{8'd0,  5'd10, 1'b0, 1'b0, 1'b0},  // zero delay, 10-byte frame
    '{8'd3,  5'd1,  1'b0, 1'b0, 1'b1},  // single byte, retrigger mid-frame
    '{8'd2,  5'd0,  1'b1, 1'b0, 1'b0},  // start-of-frame only
    '{8'd1,  5'd3,  1'b0, 1'b1, 1'b0},  // runs dry after 3 bytes
    '{8'd4,  5'd2,  1'b0, 1'b0, 1'b0},  // normal frame clears the flag
    '{8'd5,  5'd0,  1'b0, 1'b1, 1'b0}   // dry at first slot
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       halfTick = 1'b0;
  logic [1:0] tickCnt = '0;
  logic       trigger = 1'b0;
  logic       sofOnly = 1'b0;
  logic [7:0] delayVal = '0;
  logic [7:0] inData;
  logic       inValid, inLast, inReady, modOut, busy, underflow;

  logic [7:0] feedData [32];
  logic [5:0] feedIdx = '0;
  logic [5:0] feedCount = '0;
  logic [5:0] lastIdx = 6'd63;
  logic       feedRst = 1'b0;

  int total = 0;
  int bad = 0;
  int wdCnt = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    tickCnt  <= tickCnt + 2'd1;
    halfTick <= (tickCnt == 2'd2);
  end

  always @(posedge clk) begin
    if (feedRst) feedIdx <= '0;
    else if (inValid && inReady) feedIdx <= feedIdx + 6'd1;
  end

  assign inValid = (feedIdx < feedCount);
  assign inLast  = (feedIdx == lastIdx);
  assign inData  = feedData[feedIdx[4:0]];

  mfe_top i_mfe_top (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .trigger(trigger),
    .sofOnly(sofOnly), .delayVal(delayVal), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .modOut(modOut), .busy(busy), .underflow(underflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    wdCnt <= wdCnt + 1;
    if (wdCnt == 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", wdCnt, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runCase(input int c);
    case_t cs;
    bit    expMod [320];
    int    len, d, n, b1, b2, b3, reg_;
    bit    regBad [6];
    bit    regUsed [6];
    int    regAct [6];
    int    regExp [6];
    bit    sofSeq [8];
    bit    eofSeq [8];
    bit    prevMod, stabBad, m, bz;
    string regName [6];
    sofSeq  = '{0, 0, 0, 1, 1, 1, 0, 1};
    eofSeq  = '{1, 0, 1, 1, 1, 0, 0, 0};
    regName = '{"R2 delay", "R3 start-of-frame", "R4 data bits",
                "R6 end-of-frame", "R8 busy/end", "R11 strobe-only change"};
    cs = CASES[c];
    d  = int'(cs.dly);
    n  = int'(cs.nBytes);
    for (int i = 0; i < 32; i++) feedData[i] = 8'(i * 75 + c * 29);
    for (int i = 0; i < 6; i++) begin regBad[i] = 0; regUsed[i] = 0; end

    len = 0;
    for (int i = 0; i < d; i++) expMod[len++] = 1'b0;
    for (int i = 0; i < 8; i++) expMod[len++] = sofSeq[i];
    b1 = len;
    if (!cs.sofOnly) begin
      for (int b = 0; b < n; b++)
        for (int j = 0; j < 8; j++) begin
          expMod[len++] = ~feedData[b][j];
          expMod[len++] =  feedData[b][j];
        end
    end
    b2 = len;
    if (!cs.sofOnly) for (int i = 0; i < 8; i++) expMod[len++] = eofSeq[i];
    b3 = len;

    @(negedge clk);
    while (halfTick) @(negedge clk);
    feedCount = cs.sofOnly ? 6'd1 : 6'(n);
    lastIdx   = (cs.sofOnly || cs.starve) ? 6'd63 : 6'(n - 1);
    feedRst   = 1'b1;
    trigger   = 1'b1;
    sofOnly   = cs.sofOnly;
    delayVal  = cs.dly;
    @(negedge clk);
    trigger = 1'b0;
    feedRst = 1'b0;
    sofOnly = 1'b0;
    check(busy === 1'b1, "R8", $sformatf("busy after trigger case %0d", c), busy, 1);

    prevMod = modOut;
    stabBad = 0;
    for (int k = 0; k <= b3; k++) begin
      while (!halfTick) begin
        if (modOut !== prevMod) stabBad = 1;
        @(negedge clk);
      end
      @(negedge clk);
      m  = modOut;
      bz = busy;
      prevMod = m;
      if (k == b3) begin
        reg_ = 4;
        regUsed[4] = 1;
        if (m !== 1'b0 || bz !== 1'b0) begin
          if (!regBad[4]) begin regAct[4] = {m, bz}; regExp[4] = 0; end
          regBad[4] = 1;
        end
      end else begin
        reg_ = (k < d) ? 0 : (k < b1) ? 1 : (k < b2) ? 2 : 3;
        regUsed[reg_] = 1;
        if (m !== expMod[k]) begin
          if (!regBad[reg_]) begin regAct[reg_] = m; regExp[reg_] = expMod[k]; end
          regBad[reg_] = 1;
        end
        if (bz !== 1'b1) begin
          if (!regBad[4]) begin regAct[4] = bz; regExp[4] = 1; end
          regBad[4] = 1;
          regUsed[4] = 1;
        end
      end
      if (cs.retrig && k == 10) begin
        trigger  = 1'b1;
        delayVal = 8'd0;
        @(negedge clk);
        trigger = 1'b0;
      end
    end
    regUsed[5] = 1;
    regBad[5]  = stabBad;
    regAct[5]  = stabBad;
    regExp[5]  = 0;

    for (int i = 0; i < 6; i++)
      if (regUsed[i])
        check(!regBad[i], regName[i], $sformatf("case %0d", c), regAct[i], regExp[i]);

    if (cs.retrig)
      check(!(regBad[0] || regBad[1] || regBad[2] || regBad[3] || regBad[4]),
            "R10", $sformatf("frame unchanged by retrigger case %0d", c), 0, 0);

    if (cs.sofOnly)
      check(feedIdx == 0, "R7", $sformatf("bytes taken in sof-only case %0d", c),
            int'(feedIdx), 0);
    else
      check(int'(feedIdx) == n, "R5", $sformatf("bytes taken case %0d", c),
            int'(feedIdx), n);

    check(underflow === cs.starve, "R9", $sformatf("underflow flag case %0d", c),
          underflow, int'(cs.starve));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) feedData[i] = '0;
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    check(modOut === 1'b0 && busy === 1'b0, "R1", "idle during reset", {modOut, busy}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(modOut === 1'b0, "R1", "modOut after reset", modOut, 0);
    check(busy === 1'b0 && underflow === 1'b0 && inReady === 1'b0, "R1",
          "busy/underflow/ready after reset", {busy, underflow, inReady}, 0);

    for (int c = 0; c < NCASE; c++) runCase(c);

    // R1: reset in the middle of a frame
    for (int i = 0; i < 32; i++) feedData[i] = 8'hA5;
    feedCount = 6'd2;
    lastIdx   = 6'd1;
    @(negedge clk);
    feedRst  = 1'b1;
    trigger  = 1'b1;
    delayVal = 8'd0;
    @(negedge clk);
    feedRst = 1'b0;
    trigger = 1'b0;
    repeat (60) @(negedge clk);
    check(busy === 1'b1, "R8", "busy mid-frame before reset", busy, 1);
    rstN = 1'b0;
    @(negedge clk);
    check(modOut === 1'b0 && busy === 1'b0 && inReady === 1'b0, "R1",
          "idle after mid-frame reset", {modOut, busy, inReady}, 0);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
    check(modOut === 1'b0 && busy === 1'b0, "R1", "stays idle after reset release",
          {modOut, busy}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule